// File: doc/BRIEF.md
# Sleep Interval Timer with Interval-Locked Watchdog

This block divides a low-speed oscillator tick into one of four power-of-two wake-up intervals. Each time the running count completes an interval, a single-clock wake pulse goes to the interrupt logic so that a sleeping processor can resume. A 2-bit select input picks the interval length. A new select value is taken only when the current interval completes, so an interval that is already running is never shortened or stretched.

The same interval boundaries also drive a watchdog. When the watchdog is enabled, it counts completed intervals. If software has not pulsed the clear input before the third boundary, the watchdog emits a one-clock reset pulse. The watchdog period therefore follows the selected sleep interval, at roughly three intervals, and has no prescaler of its own. The oscillator and the interrupt controller sit outside this block. The tick input is a one-clock enable that is synchronous to the block clock.

Top module: `sleep_wdt_timer`

## Requirements
- R1: The interval length, in ticks, is 64 for select code 00, 512 for code 01, 4096 for code 10 and 32768 for code 11.
- R2: After a synchronous active-low reset, the active select is 00, the interval count is zero, and both output pulses are low.
- R3: The wake pulse is high for exactly one clock. It appears in the clock after the edge at which the tick completes an interval.
- R4: The interval count advances only on clocks where tick is high. With tick low, no wake pulse and no watchdog pulse occur.
- R5: A change of the select input takes effect only at the next interval completion. The interval in progress keeps its length, and the select value present at the completing edge sets the length of the next interval.
- R6: With the watchdog enabled and no clear, the watchdog pulse is high for one clock, in the same clock as the wake pulse of the third interval completion after the last clear, enable or watchdog pulse.
- R7: A clear strobe sets the watchdog count to zero. If a clear arrives in the same clock as an interval completion, that completion is not counted.
- R8: While the watchdog enable is low, the watchdog count is held at zero and no watchdog pulse is produced.
- R9: After a watchdog pulse, counting restarts from zero, so with no clear the next pulse follows three intervals later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-clock enable from the low-speed oscillator |
| ivl_sel | input | 2 | Interval select code, taken at each interval completion |
| wdt_en | input | 1 | Watchdog enable |
| wdt_clr | input | 1 | Watchdog clear strobe |
| wake_pulse | output | 1 | One-clock wake-up pulse at each interval completion |
| wdt_rst_pulse | output | 1 | One-clock watchdog reset pulse |

## Verification
Both outputs are registered. The wake pulse and the watchdog pulse appear in the clock after the edge at which the completing tick is sampled, so every result is due one clock after the stimulus that causes it. The bench drives inputs on the falling edge and runs a reference model that updates on the rising edge. It compares outputs on the following falling edge, so each comparison sees exactly one register stage. Directed checks measure intervals as the number of falling edges between two observed wake pulses. For a clear that coincides with a completion, the bench places the strobe 63 falling edges after the wake pulse it observed.

// File: rtl/sleep_wdt_pkg.sv
// Package: shared select encoding and sizing for the sleep interval timer.
// Assumes a 2-bit select field; every code maps to a power-of-two interval.
package sleep_wdt_pkg;
    localparam int SEL_W = 2;
    localparam int NUM_CODES = 1 << SEL_W;

    typedef logic [SEL_W-1:0] ivl_sel_t;

    typedef enum logic [SEL_W-1:0] {
        IVL_SHORTEST = 2'b00,
        IVL_SHORT    = 2'b01,
        IVL_LONG     = 2'b10,
        IVL_LONGEST  = 2'b11
    } ivl_code_e;
endpackage

// File: rtl/sws_interval_sel.sv
// Module: sws_interval_sel
// Holds the active interval select and provides the terminal count of the
// active interval. The select input is taken only on an interval wrap, so a
// running interval keeps its length. Assumes BASE_LOG2 + STEP_LOG2*3 < 31.
module sws_interval_sel
    import sleep_wdt_pkg::*;
#(
    parameter int BASE_LOG2 = 6,
    parameter int STEP_LOG2 = 3,
    parameter int CNT_W     = BASE_LOG2 + STEP_LOG2 * (NUM_CODES - 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  ivl_sel_t         sel_in,
    input  logic             wrap,
    output ivl_sel_t         sel_act,
    output logic [CNT_W-1:0] last_cnt
);
    logic [CNT_W-1:0] term_tbl [NUM_CODES];

    // One terminal count per select code, derived from the sizing parameters.
    for (genvar i = 0; i < NUM_CODES; i++) begin : g_term
        assign term_tbl[i] = CNT_W'((32'd1 << (BASE_LOG2 + STEP_LOG2 * i)) - 32'd1);
    end

    // Latch a new select only when the current interval completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_act <= IVL_SHORTEST;
        end else if (wrap) begin
            sel_act <= sel_in;
        end
    end

    // Terminal count of the interval now running.
    always_comb begin
        last_cnt = term_tbl[sel_act];
    end

    AST_SEL_HOLD_MIDWAY: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap |=> $stable(sel_act)); // R5
    AST_SEL_TAKEN_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> sel_act == $past(sel_in)); // R5
endmodule

// File: rtl/sws_tick_counter.sv
// Module: sws_tick_counter
// Counts low-speed ticks up to a supplied terminal count. It raises a
// combinational wrap strobe on the completing tick and a registered one-clock
// wake pulse after it. Assumes the terminal count only changes on a wrap.
module sws_tick_counter #(
    parameter int CNT_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [CNT_W-1:0] last_cnt,
    output logic             wrap,
    output logic             wake_pulse
);
    logic [CNT_W-1:0] cnt_q;

    // The completing tick of the running interval.
    always_comb begin
        wrap = tick && (cnt_q == last_cnt);
    end

    // Advance on each tick, return to zero on completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (wrap) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Register the completion into a single-clock wake pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wake_pulse <= 1'b0;
        end else begin
            wake_pulse <= wrap;
        end
    end

    AST_CNT_IDLE_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(cnt_q)); // R4
    AST_WAKE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |=> !wake_pulse); // R3
    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= last_cnt); // R1
endmodule

// File: rtl/sws_wdt.sv
// Module: sws_wdt
// Watchdog that counts interval completions. It fires a one-clock reset
// pulse on completion number WDT_LIMIT since the last clear, enable or
// firing. A clear wins over a completion in the same clock. Assumes
// WDT_LIMIT >= 2.
module sws_wdt #(
    parameter int WDT_LIMIT = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic clr,
    input  logic boundary,
    output logic wdt_rst
);
    localparam int WCW = $clog2(WDT_LIMIT);
    localparam logic [WCW-1:0] LAST = WCW'(WDT_LIMIT - 1);

    logic [WCW-1:0] wcnt_q;
    logic           fire;

    // Fire when the final completion lands with no clear pending.
    always_comb begin
        fire = en && !clr && boundary && (wcnt_q == LAST);
    end

    // Completion count: held at zero when disabled, zeroed by clear or firing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wcnt_q <= '0;
        end else if (!en || clr || fire) begin
            wcnt_q <= '0;
        end else if (boundary) begin
            wcnt_q <= wcnt_q + 1'b1;
        end
    end

    // Register the firing into a single-clock reset pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wdt_rst <= 1'b0;
        end else begin
            wdt_rst <= fire;
        end
    end

    AST_WDT_OFF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (wcnt_q == '0) && !wdt_rst); // R8
    AST_WDT_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (wcnt_q == '0) && !wdt_rst); // R7
    AST_WDT_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        wcnt_q <= LAST); // R6
    AST_WDT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_rst |=> !wdt_rst && (wcnt_q == '0)); // R9
endmodule

// File: rtl/sleep_wdt_timer.sv
// Module: sleep_wdt_timer (top)
// Sleep interval timer with a watchdog locked to the selected interval.
// Assumes tick is a one-clock enable synchronous to clk and that reset is
// synchronous and active low.
module sleep_wdt_timer
    import sleep_wdt_pkg::*;
#(
    parameter int BASE_LOG2 = 6,
    parameter int STEP_LOG2 = 3,
    parameter int WDT_LIMIT = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [SEL_W-1:0] ivl_sel,
    input  logic             wdt_en,
    input  logic             wdt_clr,
    output logic             wake_pulse,
    output logic             wdt_rst_pulse
);
    localparam int CNT_W = BASE_LOG2 + STEP_LOG2 * (NUM_CODES - 1);

    ivl_sel_t         sel_act;
    logic [CNT_W-1:0] last_cnt;
    logic             wrap;

    sws_interval_sel #(
        .BASE_LOG2 (BASE_LOG2),
        .STEP_LOG2 (STEP_LOG2),
        .CNT_W     (CNT_W)
    ) u_sel (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_in   (ivl_sel),
        .wrap     (wrap),
        .sel_act  (sel_act),
        .last_cnt (last_cnt)
    );

    sws_tick_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .last_cnt   (last_cnt),
        .wrap       (wrap),
        .wake_pulse (wake_pulse)
    );

    sws_wdt #(
        .WDT_LIMIT (WDT_LIMIT)
    ) u_wdt (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (wdt_en),
        .clr      (wdt_clr),
        .boundary (wrap),
        .wdt_rst  (wdt_rst_pulse)
    );

    AST_WDT_WITH_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_rst_pulse |-> wake_pulse); // R6
    AST_NO_TICK_NO_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> !wake_pulse && !wdt_rst_pulse); // R4
endmodule

// File: tb/sim_sleep_wdt_timer.sv
// Bench for sleep_wdt_timer: a per-clock reference model under seeded random
// stimulus, plus directed interval and watchdog corner cases.
module sim_sleep_wdt_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [1:0] ivl_sel = 2'b00;
    logic       wdt_en = 1'b0;
    logic       wdt_clr = 1'b0;
    logic       wake_pulse;
    logic       wdt_rst_pulse;

    int checks = 0;
    int fails = 0;
    bit model_on = 1'b0;
    bit done = 1'b0;

    // Reference model state.
    int   m_cnt = 0;
    int   m_sel = 0;
    int   m_wdt = 0;
    logic m_wake = 1'b0;
    logic m_rst = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    sleep_wdt_timer u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .tick          (tick),
        .ivl_sel       (ivl_sel),
        .wdt_en        (wdt_en),
        .wdt_clr       (wdt_clr),
        .wake_pulse    (wake_pulse),
        .wdt_rst_pulse (wdt_rst_pulse)
    );

    // Interval length in ticks per select code (R1).
    function automatic int ivl_len(input int code);
        return 64 << (3 * code);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Model update from the requirements at each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_sel = 0; m_wdt = 0; m_wake = 0; m_rst = 0;
            model_on = 1'b1;
        end else begin
            automatic bit bnd = tick && (m_cnt == ivl_len(m_sel) - 1);
            m_rst = 0;
            if (!wdt_en || wdt_clr) m_wdt = 0;
            else if (bnd) begin
                if (m_wdt == 2) begin m_wdt = 0; m_rst = 1; end
                else m_wdt = m_wdt + 1;
            end
            if (bnd) begin m_cnt = 0; m_sel = int'(ivl_sel); end
            else if (tick) m_cnt = m_cnt + 1;
            m_wake = bnd;
        end
    end

    // Compare outputs with the model between edges.
    always @(negedge clk) begin
        if (model_on) begin
            check(wake_pulse === m_wake, "R3 wake vs model", int'(wake_pulse), int'(m_wake));
            check(wdt_rst_pulse === m_rst, "R6 wdt vs model", int'(wdt_rst_pulse), int'(m_rst));
        end
    end

    // Falling edges until the next observed wake pulse.
    task automatic gap(output int n);
        n = 0;
        do begin @(negedge clk); n++; end while (wake_pulse !== 1'b1 && n < 40000);
    endtask

    // Wake pulses until a watchdog pulse; zero if none within max.
    task automatic wakes_to_wdt(input int max, output int n);
        int g;
        n = 0;
        for (int i = 1; i <= max; i++) begin
            gap(g);
            if (wdt_rst_pulse === 1'b1) begin n = i; return; end
        end
    endtask

    initial begin
        int g;
        int n;
        void'($urandom(1234));
        repeat (3) @(negedge clk);
        check(wake_pulse === 1'b0 && wdt_rst_pulse === 1'b0, "R2 reset outputs", int'(wake_pulse), 0);
        rst_n = 1'b1;
        tick = 1'b1;

        // R2 / R1: first interval after reset uses code 00.
        gap(g);
        check(g == 64, "R2 first interval", g, 64);

        // R1: each code, set then measure the interval after the next wrap.
        for (int c = 0; c < 4; c++) begin
            ivl_sel = 2'(c);
            gap(g);
            gap(g);
            check(g == ivl_len(c), "R1 interval length", g, ivl_len(c));
        end

        // R5: change select mid-interval; running interval keeps its length.
        ivl_sel = 2'b00;
        gap(g);                 // finishes the code-11 interval, 00 latched
        gap(g);
        check(g == 64, "R5 baseline", g, 64);
        repeat (20) @(negedge clk);
        ivl_sel = 2'b01;
        gap(g);
        check(g == 44, "R5 running interval kept", g, 44);
        ivl_sel = 2'b00;
        gap(g);
        check(g == 512, "R5 new length at wrap", g, 512);

        // R4: no ticks, no progress and no pulses.
        gap(g);
        repeat (10) @(negedge clk);
        tick = 1'b0;
        n = 0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (wake_pulse || wdt_rst_pulse) n++;
        end
        check(n == 0, "R4 idle without tick", n, 0);
        tick = 1'b1;
        gap(g);
        check(g == 54, "R4 count resumes", g, 54);

        // R6: watchdog fires with the third wake.
        wdt_en = 1'b1;
        wakes_to_wdt(6, n);
        check(n == 3, "R6 wdt on third boundary", n, 3);
        // R9: restart from zero after firing.
        wakes_to_wdt(6, n);
        check(n == 3, "R9 restart after fire", n, 3);

        // R7: clear after two wakes postpones firing.
        gap(g); gap(g);
        @(negedge clk) wdt_clr = 1'b1;
        @(negedge clk) wdt_clr = 1'b0;
        wakes_to_wdt(6, n);
        check(n == 3, "R7 clear restarts count", n, 3);

        // R7: clear in the same clock as the completing tick.
        gap(g); gap(g);                  // two counted
        repeat (63) @(negedge clk);
        wdt_clr = 1'b1;                  // sampled at the completing edge
        @(negedge clk) wdt_clr = 1'b0;
        check(wake_pulse === 1'b1 && wdt_rst_pulse === 1'b0, "R7 clear beats boundary",
              int'(wdt_rst_pulse), 0);
        wakes_to_wdt(6, n);
        check(n == 3, "R7 coincident boundary not counted", n, 3);

        // R8: disabled watchdog never fires and restarts from zero.
        wdt_en = 1'b0;
        wakes_to_wdt(6, n);
        check(n == 0, "R8 disabled no pulse", n, 0);
        gap(g);
        @(negedge clk) wdt_en = 1'b1;
        wakes_to_wdt(6, n);
        check(n == 3, "R8 count held at zero", n, 3);

        // Random phase: model comparison covers every clock.
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            tick = ($urandom % 4) != 0;
            wdt_clr = ($urandom % 300) == 0;
            if (($urandom % 500) == 0) ivl_sel = 2'($urandom % 2);
            if (($urandom % 3000) == 0) wdt_en = ~wdt_en;
        end
        done = 1'b1;
    end

    // Watchdog on the whole run.
    initial begin
        for (int i = 0; i < 190000 && !done; i++) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog timeout actual=%0d expected=%0d", 0, 1);
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule